// File: doc/BRIEF.md
# Serial Transmitter with Line Break and Flow Control

This block is a single-channel asynchronous serial transmitter. A host writes characters into a small holding buffer with a one-cycle write strobe. The transmitter takes them out one at a time and shifts each onto the serial line: a low start bit, 5 to 8 data bits least significant bit first, an optional parity bit and one or two high stop bits. Bit timing comes from an external transmit clock enable. Each bit lasts either one enable pulse or sixteen, as chosen by a mode input.

A separate command strobe carries four operations: raise a line break, drop a line break, assert the request-to-send output and negate it. A break waits for the character on the line to finish. It then holds the line low until it is released, and any character written while a break is requested is thrown away. Two mode inputs add flow control. The first makes a new character wait until clear-to-send is high. The second clears request-to-send on its own once the buffer is empty and the last stop bit has left the line.

Top module: `sertx_core`

## Requirements
- R1: After reset, and whenever no character is on the line and no break is active, `txd_o` is high. After reset `empty_o` is 1. With `tx_en_i` low, no new character starts even if characters are queued.
- R2: A character goes out as one low start bit, then 5+`wlen_i` data bits least significant bit first. `wlen_i` = 00 gives 5 bits and 11 gives 8 bits, and unused upper bits of `wdata_i` are ignored.
- R3: `par_i` = 01 adds an even parity bit and `par_i` = 10 adds an odd parity bit, sent after the data bits. `par_i` = 00 or 11 adds no parity bit.
- R4: `stop2_i` = 0 gives one high stop bit and `stop2_i` = 1 gives two. A queued character starts immediately after the last stop bit, with no extra idle bit.
- R5: With `over16_i` = 0 a bit lasts one `tick_i` pulse. With `over16_i` = 1 a bit lasts sixteen pulses.
- R6: The holding buffer stores DEPTH characters. `rdy_o` is 1 while the buffer has a free slot and drops after the write that fills it. A write to a full buffer is discarded.
- R7: `cmd_op_i` = 00 with `cmd_i` requests a break. The break begins once the current character's stop bits end, and it holds `txd_o` low until `cmd_op_i` = 01 with `cmd_i` releases it. At least one high bit follows the release.
- R8: A write made while a break is requested or active is discarded and never sent.
- R9: With `cts_gate_i` = 1, a new character starts only while `cts_i` = 1. A character already started always completes.
- R10: `cmd_op_i` = 10 sets `rts_o` and `cmd_op_i` = 11 clears it. When `auto_rts_i` = 1, `rts_o` clears by itself once the last stop bit ends with the buffer empty. When `auto_rts_i` = 0, `rts_o` is left unchanged at that point.
- R11: When the line is idle, a written character's start bit begins at the first bit boundary after the write, so at most one bit time later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmitter enable; low blocks new characters |
| tick_i | input | 1 | Transmit clock enable |
| over16_i | input | 1 | 0: one tick per bit, 1: sixteen ticks per bit |
| wlen_i | input | 2 | Data bits minus five |
| par_i | input | 2 | Parity: 01 even, 10 odd, others none |
| stop2_i | input | 1 | 1 selects two stop bits |
| cts_gate_i | input | 1 | Enables clear-to-send gating |
| cts_i | input | 1 | Clear-to-send, active high |
| auto_rts_i | input | 1 | Enables automatic request-to-send clearing |
| wr_i | input | 1 | Write strobe for the holding buffer |
| wdata_i | input | DATA_W | Character to write |
| cmd_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code: 00 break on, 01 break off, 10 RTS on, 11 RTS off |
| txd_o | output | 1 | Serial output line |
| rdy_o | output | 1 | Holding buffer can accept a character |
| empty_o | output | 1 | Buffer empty and no character or break on the line |
| rts_o | output | 1 | Request-to-send, active high |

## Verification
The hardest cases to reach from the ports are a break request that arrives in the middle of a character and a flow-control change that happens while a character is already being sent. The bench handles both by running a serial line decoder alongside a stimulus thread. That thread waits for the falling edge of the start bit and then, a few cycles into the character, issues the break command or drops clear-to-send. The decoder then confirms that the character still arrives intact. Automatic request-to-send clearing is reached by sending two back-to-back characters, which shows the output stays set between them and clears only after the second one's stop bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned MIN_WORD = 5;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_START = 3'd1,
        FS_DATA  = 3'd2,
        FS_PAR   = 3'd3,
        FS_STOP  = 3'd4,
        FS_BRK   = 3'd5
    } frame_st_e;

    typedef enum logic [1:0] {
        OP_BRK_ON  = 2'b00,
        OP_BRK_OFF = 2'b01,
        OP_RTS_ON  = 2'b10,
        OP_RTS_OFF = 2'b11
    } op_e;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int unsigned OVS = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic over_i,
    output logic bstb_o
);
    localparam int unsigned SW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [SW-1:0] LAST = SW'(OVS - 1);

    typedef struct packed {
        logic [SW-1:0] sub;
    } baud_t;

    baud_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            state_d.sub = (state_q.sub == LAST) ? '0 : state_q.sub + 1'b1;
        end
        bstb_o = tick_i & (~over_i | (state_q.sub == LAST));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] ALAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } hold_t;

    hold_t state_d, state_q;
    logic  do_push, do_pop;

    always_comb begin
        state_d = state_q;
        do_push = push_i && (state_q.cnt != CFULL);
        do_pop  = pop_i && (state_q.cnt != '0);
        if (do_push) begin
            state_d.mem[state_q.wp] = wdata_i;
            state_d.wp = (state_q.wp == ALAST) ? '0 : state_q.wp + 1'b1;
        end
        if (do_pop) begin
            state_d.rp = (state_q.rp == ALAST) ? '0 : state_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   state_d.cnt = state_q.cnt + 1'b1;
            2'b01:   state_d.cnt = state_q.cnt - 1'b1;
            default: state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign rdata_o = state_q.mem[state_q.rp];
    assign empty_o = (state_q.cnt == '0);
    assign full_o  = (state_q.cnt == CFULL);
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         bstb_i,
    input  logic         avail_i,
    input  logic         go_i,
    input  logic         brk_i,
    input  logic [W-1:0] data_i,
    input  logic [1:0]   wlen_i,
    input  logic [1:0]   par_i,
    input  logic         stop2_i,
    output logic         pop_o,
    output logic         txd_o,
    output logic         idle_o,
    output logic         done_o
);
    localparam int unsigned CW = $clog2(W);

    typedef struct packed {
        frame_st_e     st;
        logic [W-1:0]  sh;
        logic [CW-1:0] idx;
        logic          pbit;
        logic          second;
    } frame_t;

    frame_t        state_d, state_q;
    logic [CW-1:0] last_idx;
    logic [W-1:0]  mask;
    logic          par_en;
    logic          launch;

    always_comb begin
        last_idx = CW'(MIN_WORD - 1) + CW'(wlen_i);
        par_en   = (par_i == 2'b01) || (par_i == 2'b10);
        for (int i = 0; i < W; i++) begin
            mask[i] = (i <= int'(last_idx));
        end

        state_d = state_q;
        pop_o   = 1'b0;
        done_o  = 1'b0;
        launch  = 1'b0;

        if (bstb_i) begin
            case (state_q.st)
                FS_IDLE:  launch = 1'b1;
                FS_START: begin
                    state_d.st  = FS_DATA;
                    state_d.idx = '0;
                end
                FS_DATA: begin
                    if (state_q.idx == last_idx) begin
                        state_d.st     = par_en ? FS_PAR : FS_STOP;
                        state_d.second = 1'b0;
                    end else begin
                        state_d.sh  = state_q.sh >> 1;
                        state_d.idx = state_q.idx + 1'b1;
                    end
                end
                FS_PAR: begin
                    state_d.st     = FS_STOP;
                    state_d.second = 1'b0;
                end
                FS_STOP: begin
                    if (stop2_i && !state_q.second) state_d.second = 1'b1;
                    else                            launch = 1'b1;
                end
                FS_BRK: begin
                    if (!brk_i) state_d.st = FS_IDLE;
                end
                default: state_d.st = FS_IDLE;
            endcase
        end

        if (launch) begin
            if (brk_i) begin
                state_d.st = FS_BRK;
            end else if (avail_i && go_i) begin
                state_d.st   = FS_START;
                state_d.sh   = data_i & mask;
                state_d.pbit = (^(data_i & mask)) ^ (par_i == 2'b10);
                pop_o        = 1'b1;
            end else begin
                state_d.st = FS_IDLE;
            end
            done_o = (state_q.st == FS_STOP) && !pop_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    always_comb begin
        case (state_q.st)
            FS_START: txd_o = 1'b0;
            FS_DATA:  txd_o = state_q.sh[0];
            FS_PAR:   txd_o = state_q.pbit;
            FS_BRK:   txd_o = 1'b0;
            default:  txd_o = 1'b1;
        endcase
    end

    assign idle_o = (state_q.st == FS_IDLE);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tx_en_i,
    input  logic              tick_i,
    input  logic              over16_i,
    input  logic [1:0]        wlen_i,
    input  logic [1:0]        par_i,
    input  logic              stop2_i,
    input  logic              cts_gate_i,
    input  logic              cts_i,
    input  logic              auto_rts_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cmd_i,
    input  logic [1:0]        cmd_op_i,
    output logic              txd_o,
    output logic              rdy_o,
    output logic              empty_o,
    output logic              rts_o
);
    typedef struct packed {
        logic brk;
        logic rts;
    } ctl_t;

    ctl_t              state_d, state_q;
    logic              bstb;
    logic              push, go;
    logic              h_empty, h_full;
    logic [DATA_W-1:0] h_rdata;
    logic              f_pop, f_idle, f_done, f_txd;
    logic              brk_on;

    sertx_baud #(.OVS(OVS)) u_baud (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .over_i (over16_i),
        .bstb_o (bstb)
    );

    sertx_hold #(.W(DATA_W), .DEPTH(DEPTH)) u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (push),
        .wdata_i (wdata_i),
        .pop_i   (f_pop),
        .rdata_o (h_rdata),
        .empty_o (h_empty),
        .full_o  (h_full)
    );

    sertx_frame #(.W(DATA_W)) u_frame (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .bstb_i  (bstb),
        .avail_i (!h_empty),
        .go_i    (go),
        .brk_i   (state_q.brk),
        .data_i  (h_rdata),
        .wlen_i  (wlen_i),
        .par_i   (par_i),
        .stop2_i (stop2_i),
        .pop_o   (f_pop),
        .txd_o   (f_txd),
        .idle_o  (f_idle),
        .done_o  (f_done)
    );

    always_comb begin
        state_d = state_q;
        push    = wr_i & ~state_q.brk;
        go      = tx_en_i & (~cts_gate_i | cts_i);
        if (cmd_i) begin
            case (cmd_op_i)
                OP_BRK_ON:  state_d.brk = 1'b1;
                OP_BRK_OFF: state_d.brk = 1'b0;
                OP_RTS_ON:  state_d.rts = 1'b1;
                OP_RTS_OFF: state_d.rts = 1'b0;
            endcase
        end else if (auto_rts_i && f_done && h_empty) begin
            state_d.rts = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign brk_on  = state_q.brk;
    assign txd_o   = f_txd;
    assign rdy_o   = ~h_full;
    assign empty_o = h_empty & f_idle;
    assign rts_o   = state_q.rts;
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic wr_i,
    input logic cmd_i,
    input logic auto_rts_i,
    input logic cts_gate_i,
    input logic cts_i,
    input logic txd_o,
    input logic rdy_o,
    input logic empty_o,
    input logic rts_o,
    input logic brk_on,
    input logic h_empty,
    input logic f_pop
);
    // R1: nothing queued and nothing on the line means the line marks
    p_mark_when_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_o |-> txd_o);

    // R6: the ready flag only falls as a result of a write
    p_rdy_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rdy_o) |-> $past(wr_i));

    // R8: while a break is requested the buffer cannot gain a character
    p_discard_break_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (brk_on && h_empty) |=> h_empty);

    // R9: a character is taken for sending only when clear-to-send allows it
    p_cts_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        f_pop |-> (!cts_gate_i || cts_i));

    // R10: request-to-send clears only by command or by the automatic mode
    p_rts_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rts_o) |-> ($past(cmd_i) || $past(auto_rts_i)));
endmodule

bind sertx_core sertx_core_chk i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .cmd_i      (cmd_i),
    .auto_rts_i (auto_rts_i),
    .cts_gate_i (cts_gate_i),
    .cts_i      (cts_i),
    .txd_o      (txd_o),
    .rdy_o      (rdy_o),
    .empty_o    (empty_o),
    .rts_o      (rts_o),
    .brk_on     (brk_on),
    .h_empty    (h_empty),
    .f_pop      (f_pop)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV  = 4;
    localparam int DEPTH = 4;
    localparam int BP1   = TDIV;
    localparam int BP16  = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_en, tick, over16, stop2, cts_gate, cts, auto_rts, wr, cmd;
    logic [1:0] wlen, par, cmd_op;
    logic [7:0] wdata;
    logic       txd, rdy, empty, rts;
    logic [1:0] tcnt = 2'd0;
    int         cyc_no = 0;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 2'd1;
    always @(posedge clk) cyc_no <= cyc_no + 1;
    assign tick = (tcnt == 2'd3);

    sertx_core #(.DATA_W(8), .DEPTH(DEPTH), .OVS(16)) i_sertx_core (
        .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .tick_i(tick),
        .over16_i(over16), .wlen_i(wlen), .par_i(par), .stop2_i(stop2),
        .cts_gate_i(cts_gate), .cts_i(cts), .auto_rts_i(auto_rts),
        .wr_i(wr), .wdata_i(wdata), .cmd_i(cmd), .cmd_op_i(cmd_op),
        .txd_o(txd), .rdy_o(rdy), .empty_o(empty), .rts_o(rts)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [7:0] v);
        wr = 1'b1; wdata = v; cyc(1); wr = 1'b0;
    endtask

    task automatic op(input logic [1:0] c);
        cmd = 1'b1; cmd_op = c; cyc(1); cmd = 1'b0;
    endtask

    task automatic wait_low(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (!txd) begin seen = 1'b1; break; end
            cyc(1);
        end
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            if (!txd) lows++;
            cyc(1);
        end
    endtask

    // decodes one character; returns at the middle of its last stop bit
    task automatic rx_frame(input int nb, input bit pen, input bit two, input int bp,
                            output logic [7:0] dat, output logic pb, output logic framed);
        bit seen;
        dat = '0; pb = 1'b0; framed = 1'b0;
        wait_low(seen);
        if (!seen) return;
        cyc(bp/2);
        framed = !txd;
        for (int i = 0; i < nb; i++) begin cyc(bp); dat[i] = txd; end
        if (pen) begin cyc(bp); pb = txd; end
        cyc(bp); framed = framed & txd;
        if (two) begin cyc(bp); framed = framed & txd; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired in R1 bench flow actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, m, got;
        logic       pb, fr;
        int         nb, n, lows, t0, t1;
        bit         pen, seen;

        rst_n = 1'b0; tx_en = 1'b1; over16 = 1'b0; stop2 = 1'b0; cts_gate = 1'b0;
        cts = 1'b1; auto_rts = 1'b0; wr = 1'b0; cmd = 1'b0; wlen = 2'b11; par = 2'b00;
        cmd_op = 2'b00; wdata = '0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);

        check("R1 reset txd", int'(txd), 1);
        check("R1 reset empty", int'(empty), 1);
        check("R6 reset rdy", int'(rdy), 1);
        check("R10 reset rts", int'(rts), 0);

        // R2 R3 R4 sweep over every framing configuration
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int k = 0; k < 2; k++) begin
                        v = 8'(wl * 53 + pm * 29 + s * 7 + 58);
                        if (k == 1) v = ~v;
                        nb  = 5 + wl;
                        m   = 8'((1 << nb) - 1);
                        pen = (pm == 1) || (pm == 2);
                        wlen = 2'(wl); par = 2'(pm); stop2 = s[0];
                        cyc(2);
                        put(v);
                        rx_frame(nb, pen, s[0], BP1, got, pb, fr);
                        check("R2 data bits", int'(got), int'(v & m));
                        if (pen) check("R3 parity bit", int'(pb), int'((^(v & m)) ^ (pm == 2)));
                        check("R4 start and stop levels", int'(fr), 1);
                        cyc(3 * BP1);
                        check("R1 idle after frame", int'(empty & txd), 1);
                    end
                end
            end
        end

        // R4 back-to-back spacing: start-to-start distance in bit times
        for (int s = 0; s < 2; s++) begin
            for (int pe = 0; pe < 2; pe++) begin
                wlen = 2'b11; par = pe[0] ? 2'b01 : 2'b00; stop2 = s[0];
                tx_en = 1'b0;
                put(8'h00); put(8'h00);
                tx_en = 1'b1;
                wait_low(seen);
                t0 = cyc_no;
                while (!txd) cyc(1);
                wait_low(seen);
                t1 = cyc_no;
                check("R4 stop count spacing", t1 - t0, (1 + 8 + pe + 1 + s) * BP1);
                cyc(14 * BP1);
            end
        end
        stop2 = 1'b0; par = 2'b00; wlen = 2'b11;

        // R11 start latency from an idle line
        cyc(10);
        put(8'h01);
        n = 0;
        while (txd && n < 100) begin cyc(1); n++; end
        check("R11 start within one bit", int'(n >= 1 && n <= TDIV), 1);
        cyc(12 * BP1);

        // R5 bit time in both modes
        put(8'hFF);
        wait_low(seen);
        n = 0;
        while (!txd && n < 500) begin cyc(1); n++; end
        check("R5 1x start bit length", n, BP1);
        cyc(12 * BP1);
        over16 = 1'b1;
        cyc(2);
        put(8'hFF);
        wait_low(seen);
        n = 0;
        while (!txd && n < 500) begin cyc(1); n++; end
        check("R5 16x start bit length", n, BP16);
        cyc(10 * BP16);
        put(8'h96);
        rx_frame(8, 1'b0, 1'b0, BP16, got, pb, fr);
        check("R5 16x data", int'(got), 8'h96);
        check("R5 16x framing", int'(fr), 1);
        cyc(2 * BP16);
        over16 = 1'b0;
        cyc(2);

        // R6 buffer depth, ready flag and overflow discard; R1 disabled hold
        tx_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            put(8'(8'h10 + i));
            check("R6 ready after write", int'(rdy), (i < DEPTH - 1) ? 1 : 0);
        end
        put(8'hEE);
        check("R6 ready stays low when full", int'(rdy), 0);
        count_low(20 * BP1, lows);
        check("R1 disabled line stays marking", lows, 0);
        tx_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            rx_frame(8, 1'b0, 1'b0, BP1, got, pb, fr);
            check("R6 queued order", int'(got), 8'h10 + i);
        end
        cyc(2 * BP1);
        count_low(30 * BP1, lows);
        check("R6 overflow write not sent", lows, 0);
        check("R6 ready after drain", int'(rdy), 1);

        // R7 break during a character, R8 write during break
        put(8'h3C);
        fork
            rx_frame(8, 1'b0, 1'b0, BP1, got, pb, fr);
            begin
                bit sn;
                wait_low(sn);
                cyc(2);
                op(2'b00);
            end
        join
        check("R7 character before break intact", int'(got), 8'h3C);
        check("R7 stop bit before break", int'(fr), 1);
        cyc(BP1);
        check("R7 break drives low", int'(txd), 0);
        put(8'h55);
        cyc(10 * BP1);
        check("R7 break held", int'(txd), 0);
        op(2'b01);
        cyc(2 * BP1);
        check("R7 line marks after release", int'(txd), 1);
        count_low(30 * BP1, lows);
        check("R8 write in break not sent", lows, 0);
        check("R8 empty after break", int'(empty), 1);

        // R9 clear-to-send gating
        cts_gate = 1'b1; cts = 1'b0;
        put(8'h81);
        count_low(20 * BP1, lows);
        check("R9 held while cts low", lows, 0);
        check("R9 character still queued", int'(empty), 0);
        fork
            rx_frame(8, 1'b0, 1'b0, BP1, got, pb, fr);
            begin cyc(3); cts = 1'b1; end
        join
        check("R9 sent after cts high", int'(got), 8'h81);
        cyc(2 * BP1);
        put(8'hA7);
        fork
            rx_frame(8, 1'b0, 1'b0, BP1, got, pb, fr);
            begin
                bit sn;
                wait_low(sn);
                cyc(2 * BP1);
                cts = 1'b0;
            end
        join
        check("R9 in-progress completes data", int'(got), 8'hA7);
        check("R9 in-progress completes stop", int'(fr), 1);
        cyc(2 * BP1);
        cts_gate = 1'b0;
        rx_frame(8, 1'b0, 1'b0, BP1, got, pb, fr);
        check("R9 gate off ignores cts", int'(got), 8'h00);
        cts = 1'b1;
        cyc(3 * BP1);

        // R10 request-to-send command and automatic clear
        auto_rts = 1'b1;
        op(2'b10);
        check("R10 rts set by command", int'(rts), 1);
        tx_en = 1'b0;
        put(8'h5A); put(8'hC3);
        tx_en = 1'b1;
        rx_frame(8, 1'b0, 1'b0, BP1, got, pb, fr);
        check("R10 first char", int'(got), 8'h5A);
        check("R10 rts held while queued", int'(rts), 1);
        rx_frame(8, 1'b0, 1'b0, BP1, got, pb, fr);
        check("R10 second char", int'(got), 8'hC3);
        check("R10 rts held during last stop", int'(rts), 1);
        cyc(BP1);
        check("R10 rts cleared after last stop", int'(rts), 0);
        auto_rts = 1'b0;
        op(2'b10);
        put(8'h11);
        rx_frame(8, 1'b0, 1'b0, BP1, got, pb, fr);
        cyc(2 * BP1);
        check("R10 rts kept without auto", int'(rts), 1);
        op(2'b11);
        check("R10 rts cleared by command", int'(rts), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule